// File: doc/BRIEF.md
# Tear-Free Split 64-Bit Counter Reader

This block fetches a 64-bit free-running counter that can only be reached through a 32-bit register read port. A plain pair of word reads can return a torn value if the low word carries into the high word between the two accesses. To avoid this, each attempt reads the upper word, then the lower word, then the upper word once more. The attempt is accepted only when both upper-word samples agree. Otherwise the whole three-read attempt is repeated.

A requester pulses `start_i` with the byte address of the counter's lower word. The block then works as a bus master on a simple 32-bit read port. Requests use a valid/ready handshake and responses may arrive after any number of wait states. The number of attempts is capped by a parameter. When the cap is reached, the block gives up and returns zero with a timeout flag. Completion is signalled by a one-cycle `done_o` pulse, with the result and the flag valid in that same cycle.

Top module: `tear_free_rd64`

## Requirements
- R1: The lower word is read at the base address, and the upper word at base plus DATA_W/8 bytes (base+4 for 32-bit words). No other address is ever requested.
- R2: Each attempt issues exactly three reads in the order upper, lower, upper.
- R3: If the two upper-word samples of an attempt differ, a fresh three-read attempt starts, beginning again with an upper-word read.
- R4: When the two upper-word samples match, the result is {first upper sample, lower sample} and the timeout flag is 0.
- R5: At most MAX_TRIES attempts are made. The budget is checked before any read of an attempt. When it is used up, the result is 0 and the timeout flag is 1, after exactly 3*MAX_TRIES reads.
- R6: Only one read is in flight at a time. A request holds its valid and address steady until accepted, and no new request is issued until the previous response has arrived.
- R7: A start pulse while the block is busy is ignored. The run in progress keeps its base address and produces exactly one completion.
- R8: `done_o` is high for exactly one cycle per run, with `value_o` and `timeout_o` valid in that cycle. `busy_o` is high from the cycle after start is accepted up to and including the done cycle.
- R9: After reset, `busy_o`, `done_o`, `rd_req_valid_o`, `timeout_o` and `value_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read of the counter at `base_addr_i` |
| base_addr_i | input | ADDR_W | Byte address of the counter's lower word |
| busy_o | output | 1 | A read sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| value_o | output | 2*DATA_W | Assembled counter value, or 0 on timeout |
| timeout_o | output | 1 | The attempt budget ran out |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_addr_o | output | ADDR_W | Read request byte address |
| rd_req_ready_i | input | 1 | Port accepts the request this cycle |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | DATA_W | Read data |

## Verification
The bench drives a port model whose upper word changes between the two upper-word samples for a chosen number of attempts, and then holds steady. The base address, the data patterns, the acceptance delay and the response delay are all varied.

With zero mismatches, a single attempt must complete. Intermediate mismatch counts show whether the retry restarts from the upper word and whether the first upper sample, rather than the second, is kept. A mismatch count of MAX_TRIES-1 separates a correct budget from an off-by-one, because it must still succeed. Counts of MAX_TRIES and above must time out with a zero value after exactly 3*MAX_TRIES reads. A start pulse injected in the middle of a run exposes any re-latching of the base address or any second completion.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_REQ   = 3'd2,
    S_WAIT  = 3'd3,
    S_FIN   = 3'd4
  } tfr_state_e;

  typedef enum logic [1:0] {
    PH_HI_A = 2'd0,
    PH_LO   = 2'd1,
    PH_HI_B = 2'd2
  } tfr_phase_e;

endpackage

// File: rtl/tfr_budget.sv
module tfr_budget #(
  parameter int MAX_TRIES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic empty_o
);
  localparam int CNT_W = $clog2(MAX_TRIES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = cnt_q;
    if (load_i)     cnt_d = CNT_W'(MAX_TRIES);
    else if (dec_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign empty_o = (cnt_q == '0);

  AST_BUDGET_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> !empty_o); // R5

endmodule

// File: rtl/tfr_capture.sv
module tfr_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi_i,
  input  logic              cap_lo_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  logic [DATA_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_q <= '0;
    else if (cap_hi_i) hi_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_q <= '0;
    else if (cap_lo_i) lo_q <= data_i;
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  AST_CAPTURE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_hi_i && cap_lo_i)); // R2

endmodule

// File: rtl/tfr_seq.sv
module tfr_seq
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic                budget_empty_i,
  output logic                budget_load_o,
  output logic                budget_dec_o,
  output logic                cap_hi_o,
  output logic                cap_lo_o,
  input  logic [DATA_W-1:0]   hi_a_i,
  input  logic [DATA_W-1:0]   lo_i,
  output logic                rd_req_valid_o,
  output logic [ADDR_W-1:0]   rd_req_addr_o,
  input  logic                rd_req_ready_i,
  input  logic                rd_rsp_valid_i,
  input  logic [DATA_W-1:0]   rd_rsp_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] value_o,
  output logic                timeout_o
);
  localparam int HI_OFS = DATA_W / 8;

  tfr_state_e         state_q, state_d;
  tfr_phase_e         phase_q, phase_d;
  logic [ADDR_W-1:0]  base_q;
  logic               base_en;
  logic [2*DATA_W-1:0] res_q, res_d;
  logic               to_q, to_d;
  logic               res_en;

  always_comb begin
    state_d       = state_q;
    phase_d       = phase_q;
    base_en       = 1'b0;
    res_en        = 1'b0;
    res_d         = res_q;
    to_d          = to_q;
    budget_load_o = 1'b0;
    budget_dec_o  = 1'b0;
    cap_hi_o      = 1'b0;
    cap_lo_o      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          base_en       = 1'b1;
          budget_load_o = 1'b1;
          state_d       = S_CHECK;
        end
      end
      S_CHECK: begin
        if (budget_empty_i) begin
          res_en  = 1'b1;
          res_d   = '0;
          to_d    = 1'b1;
          state_d = S_FIN;
        end else begin
          budget_dec_o = 1'b1;
          phase_d      = PH_HI_A;
          state_d      = S_REQ;
        end
      end
      S_REQ: begin
        if (rd_req_ready_i) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (rd_rsp_valid_i) begin
          case (phase_q)
            PH_HI_A: begin
              cap_hi_o = 1'b1;
              phase_d  = PH_LO;
              state_d  = S_REQ;
            end
            PH_LO: begin
              cap_lo_o = 1'b1;
              phase_d  = PH_HI_B;
              state_d  = S_REQ;
            end
            default: begin
              if (rd_rsp_data_i == hi_a_i) begin
                res_en  = 1'b1;
                res_d   = {hi_a_i, lo_i};
                to_d    = 1'b0;
                state_d = S_FIN;
              end else begin
                state_d = S_CHECK;
              end
            end
          endcase
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      phase_q <= PH_HI_A;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      to_q  <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
      to_q  <= to_d;
    end
  end

  assign rd_req_valid_o = (state_q == S_REQ);
  assign rd_req_addr_o  = (phase_q == PH_LO) ? base_q : base_q + ADDR_W'(HI_OFS);
  assign busy_o         = (state_q != S_IDLE);
  assign done_o         = (state_q == S_FIN);
  assign value_o        = res_q;
  assign timeout_o      = to_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o)); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && rd_req_ready_i |=> !rd_req_valid_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && timeout_o |-> value_o == '0); // R5
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(base_q)); // R7

endmodule

// File: rtl/tear_free_rd64.sv
module tear_free_rd64 #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_TRIES = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] value_o,
  output logic                timeout_o,
  output logic                rd_req_valid_o,
  output logic [ADDR_W-1:0]   rd_req_addr_o,
  input  logic                rd_req_ready_i,
  input  logic                rd_rsp_valid_i,
  input  logic [DATA_W-1:0]   rd_rsp_data_i
);
  logic              budget_load, budget_dec, budget_empty;
  logic              cap_hi, cap_lo;
  logic [DATA_W-1:0] hi_a, lo_w;

  tfr_budget #(.MAX_TRIES(MAX_TRIES)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (budget_load),
    .dec_i   (budget_dec),
    .empty_o (budget_empty)
  );

  tfr_capture #(.DATA_W(DATA_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_hi_i (cap_hi),
    .cap_lo_i (cap_lo),
    .data_i   (rd_rsp_data_i),
    .hi_o     (hi_a),
    .lo_o     (lo_w)
  );

  tfr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .base_addr_i    (base_addr_i),
    .budget_empty_i (budget_empty),
    .budget_load_o  (budget_load),
    .budget_dec_o   (budget_dec),
    .cap_hi_o       (cap_hi),
    .cap_lo_o       (cap_lo),
    .hi_a_i         (hi_a),
    .lo_i           (lo_w),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_addr_o  (rd_req_addr_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .rd_rsp_data_i  (rd_rsp_data_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .value_o        (value_o),
    .timeout_o      (timeout_o)
  );

endmodule

// File: tb/tear_free_rd64_bench.sv
module tear_free_rd64_bench;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int MAXT = 4;
  localparam int NV   = 6;

  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_2040, 32'h0000_0008,
                                          32'h0000_3000, 32'h0000_FFF0, 32'h0000_0100};
  localparam logic [31:0] V_HI   [NV] = '{32'h0000_0012, 32'hFFFF_FFF0, 32'h1234_5678,
                                          32'hAAAA_0000, 32'h0000_0007, 32'h0000_0000};
  localparam logic [31:0] V_LO   [NV] = '{32'hDEAD_BEEF, 32'h0000_0001, 32'h9ABC_DEF0,
                                          32'h5555_5555, 32'h0000_0000, 32'h0000_0001};
  localparam int V_FLIP [NV] = '{0, 1, 3, 4, 2, 9};
  localparam int V_RDLY [NV] = '{0, 2, 0, 1, 1, 0};
  localparam int V_SDLY [NV] = '{0, 1, 3, 0, 0, 2};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] base_in;
  logic          busy, done, tmo;
  logic [63:0]   value;
  logic          rq_valid;
  logic [AW-1:0] rq_addr;
  logic          rq_ready, rsp_valid;
  logic [DW-1:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_base, m_hi, m_lo;
  int m_flip, m_rdly, m_sdly;
  int hi_k, lo_j, nreads, order_bad, addr_bad, done_cnt;

  always #2 clk = ~clk;

  tear_free_rd64 #(.ADDR_W(AW), .DATA_W(DW), .MAX_TRIES(MAXT)) u_tear_free_rd64 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_in),
    .busy_o(busy), .done_o(done), .value_o(value), .timeout_o(tmo),
    .rd_req_valid_o(rq_valid), .rd_req_addr_o(rq_addr), .rd_req_ready_i(rq_ready),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // port model: one read at a time, programmable wait states
  initial begin
    rq_ready  = 1'b0;
    rsp_valid = 1'b0;
    rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rq_valid) begin
        logic is_hi;
        logic [31:0] a;
        a = rq_addr;
        is_hi = 1'b0;
        if (a == m_base + 32'd4) is_hi = 1'b1;
        else if (a != m_base) addr_bad++;
        if (is_hi == ((nreads % 3) == 1)) order_bad++;
        nreads++;
        repeat (m_rdly) @(negedge clk);
        rq_ready = 1'b1;
        @(negedge clk);
        rq_ready = 1'b0;
        repeat (m_sdly) @(negedge clk);
        if (is_hi) begin
          rsp_data = (hi_k < 2*m_flip) ? m_hi + 32'(hi_k) : m_hi + 32'(2*m_flip);
          hi_k++;
        end else begin
          rsp_data = m_lo + 32'(lo_j);
          lo_j++;
        end
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    done_cnt = 0;
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  end

  task automatic run_one(input logic [31:0] b, input logic [31:0] hb, input logic [31:0] lb,
                         input int f, input int rd, input int sd, input bit inject);
    int waited, tries, dc0;
    logic [63:0] ev;
    logic [63:0] got_v;
    logic got_t;
    m_base = b; m_hi = hb; m_lo = lb; m_flip = f; m_rdly = rd; m_sdly = sd;
    hi_k = 0; lo_j = 0; nreads = 0; order_bad = 0; addr_bad = 0;
    dc0 = done_cnt;
    @(negedge clk);
    base_in = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", {63'd0, busy}, 64'd1);
    if (inject) begin
      repeat (4) @(negedge clk);
      base_in = b ^ 32'h0000_0F00;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      base_in = b;
    end
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk("R8 done reached", {63'd0, done}, 64'd1);
    got_v = value;
    got_t = tmo;
    @(negedge clk);
    chk("R8 done one cycle", {63'd0, done}, 64'd0);
    repeat (3) @(negedge clk);
    tries = (f + 1 < MAXT) ? f + 1 : MAXT;
    ev = (f < MAXT) ? {hb + 32'(2*f), lb + 32'(f)} : 64'd0;
    if (f < MAXT) chk("R4 value", got_v, ev);
    else          chk("R5 timeout value zero", got_v, ev);
    chk("R5 timeout flag", {63'd0, got_t}, (f < MAXT) ? 64'd0 : 64'd1);
    chk("R3 R5 read count", 64'(nreads), 64'(3*tries));
    chk("R2 read order", 64'(order_bad), 64'd0);
    chk("R1 addresses", 64'(addr_bad), 64'd0);
    chk(inject ? "R7 one completion" : "R8 one completion", 64'(done_cnt - dc0), 64'd1);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<100000", wd);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    base_in = '0;
    m_base = '0; m_hi = '0; m_lo = '0; m_flip = 0; m_rdly = 0; m_sdly = 0;
    hi_k = 0; lo_j = 0; nreads = 0; order_bad = 0; addr_bad = 0;
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", {63'd0, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy", {63'd0, busy}, 64'd0);
    chk("R9 done", {63'd0, done}, 64'd0);
    chk("R9 req valid", {63'd0, rq_valid}, 64'd0);
    chk("R9 value", value, 64'd0);
    chk("R9 timeout", {63'd0, tmo}, 64'd0);

    for (int i = 0; i < NV; i++)
      run_one(V_BASE[i], V_HI[i], V_LO[i], V_FLIP[i], V_RDLY[i], V_SDLY[i], 1'b0);

    // R7: start pulse in the middle of a retrying run
    run_one(32'h0000_4400, 32'h0101_0101, 32'h0F0F_0F0F, 2, 1, 1, 1'b1);
    // R5 then R4 back to back: a timeout run does not spoil the next run
    run_one(32'h0000_5000, 32'h0000_0020, 32'h0000_0030, MAXT, 0, 0, 1'b0);
    run_one(32'h0000_5000, 32'hCAFE_0000, 32'h0000_FFFF, MAXT - 1, 0, 0, 1'b0);

    // R6: no request while idle
    repeat (5) @(negedge clk);
    chk("R6 idle no request", {63'd0, rq_valid}, 64'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule